// File: doc/BRIEF.md
# Matrix Converter Gate Pulse Decoder

This block turns a small set of carrier-comparison pulses into the twelve gate signals of a two-stage (rectifier plus inverter) matrix converter. The rectifier stage has six bidirectional switches, an upper and a lower one for each input phase a, b and c. The inverter stage has six switches, an upper and a lower one for each output leg A, B and C. A controller upstream compares its modulation signals against one shared triangular carrier. It hands this block a 3-bit input-current sector code, one modulated rectifier pulse, and two comparison pulses per inverter leg.

For the rectifier, the sector code selects one switch that stays on for the whole carrier period. It also selects two modulated switches: one follows the rectifier pulse and the other takes its complement. All other rectifier switches stay off. For each inverter leg, the upper gate is the XNOR of the leg's two comparison pulses, and the lower gate is its inverse. The sector code is captured only on a carrier-period strobe, so rectifier routing never changes inside a period. Codes 0 and 7 are not sectors and turn every gate off. All gate outputs are registered, one clock after the inputs.

Top module: `mcg_gate_decoder`

## Requirements
- R1: In sector 1 (code 3'd1), upper a is on, lower c follows the rectifier pulse, and lower b is its complement.
- R2: In sector 2 (code 3'd2), lower c is on, upper a follows the rectifier pulse, and upper b is its complement.
- R3: In sector 3 (code 3'd3), upper b is on, lower a follows the rectifier pulse, and lower c is its complement.
- R4: In sector 4 (code 3'd4), lower a is on, upper b follows the rectifier pulse, and upper c is its complement.
- R5: In sector 5 (code 3'd5), upper c is on, lower b follows the rectifier pulse, and lower a is its complement.
- R6: In sector 6 (code 3'd6), lower b is on, upper a follows the rectifier pulse, and upper c is its complement.
- R7: In every valid sector, the three rectifier switches that are neither always on nor modulated are off. Exactly one upper and one lower rectifier gate are high, and never both gates of the same input phase.
- R8: In a valid sector, each inverter upper gate equals the XNOR of the leg's first and second comparison pulses, and the lower gate is its logical inverse.
- R9: While the held sector code is 0 or 7, all twelve gates are low.
- R10: The sector code is captured only in a cycle with `period_start` high. A code change in any other cycle has no effect on any gate.
- R11: After reset, all gates are low and the held sector is invalid until the first strobe. Each gate output reflects the held sector and the pulse inputs of the previous clock cycle.

Gate vector bit order: `rect_hi`, `rect_lo` use bit 0 = phase a, bit 1 = b, bit 2 = c. `inv_*` use bit 0 = leg A, bit 1 = B, bit 2 = C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_start | input | 1 | Carrier-period boundary strobe; sector capture enable |
| sector_in | input | 3 | Input-current sector code, 1..6 valid |
| rect_pwm | input | 1 | Modulated rectifier pulse |
| leg_cmp1 | input | 3 | First carrier comparison per inverter leg |
| leg_cmp2 | input | 3 | Second carrier comparison per inverter leg |
| rect_hi | output | 3 | Rectifier upper gates, phases a..c |
| rect_lo | output | 3 | Rectifier lower gates, phases a..c |
| inv_hi | output | 3 | Inverter upper gates, legs A..C |
| inv_lo | output | 3 | Inverter lower gates, legs A..C |

## Verification
Every sector code is driven with the rectifier pulse both low and high. This tells the always-on switch apart from the follower and from the complement, and catches a swapped modulated pair. All four pulse combinations are applied per inverter leg, so XNOR can be told apart from XOR, AND or a single comparison. The two invalid codes are checked for a full shutdown. A code change without the strobe must leave routing unchanged, which separates sampled capture from a transparent path. A long seeded random run then mixes strobe timing, codes and pulses against a bench-side mapping table.

// File: rtl/mcg_pkg.sv
package mcg_pkg;
  localparam int SEC_W    = 3;
  localparam int RECT_PH  = 3;
  localparam logic [SEC_W-1:0] SEC_NONE_LO = 3'd0;
  localparam logic [SEC_W-1:0] SEC_NONE_HI = 3'd7;

  typedef logic [SEC_W-1:0] sec_t;

  typedef struct packed {
    logic [RECT_PH-1:0] lo;
    logic [RECT_PH-1:0] hi;
  } rect_gates_t;

  function automatic logic sec_ok(input sec_t s);
    return (s != SEC_NONE_LO) && (s != SEC_NONE_HI);
  endfunction
endpackage

// File: rtl/mcg_sector_hold.sv
module mcg_sector_hold
  import mcg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic period_start,
  input  sec_t sector_in,
  output sec_t sector_q
);
  always_ff @(posedge clk) begin
    if (rst)               sector_q <= SEC_NONE_LO;
    else if (period_start) sector_q <= sector_in;
  end

  // R10: held code moves only on a period strobe
  a_r10_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
    !period_start |=> $stable(sector_q));
endmodule

// File: rtl/mcg_rect_route.sv
module mcg_rect_route
  import mcg_pkg::*;
(
  input  sec_t        sector,
  input  logic        pwm,
  output rect_gates_t gates
);
  localparam int PA = 0;
  localparam int PB = 1;
  localparam int PC = 2;

  always_comb begin
    gates = '0;
    unique case (sector)
      3'd1: begin gates.hi[PA] = 1'b1; gates.lo[PC] = pwm; gates.lo[PB] = ~pwm; end
      3'd2: begin gates.lo[PC] = 1'b1; gates.hi[PA] = pwm; gates.hi[PB] = ~pwm; end
      3'd3: begin gates.hi[PB] = 1'b1; gates.lo[PA] = pwm; gates.lo[PC] = ~pwm; end
      3'd4: begin gates.lo[PA] = 1'b1; gates.hi[PB] = pwm; gates.hi[PC] = ~pwm; end
      3'd5: begin gates.hi[PC] = 1'b1; gates.lo[PB] = pwm; gates.lo[PA] = ~pwm; end
      3'd6: begin gates.lo[PB] = 1'b1; gates.hi[PA] = pwm; gates.hi[PC] = ~pwm; end
      default: gates = '0;
    endcase
  end
endmodule

// File: rtl/mcg_inv_leg.sv
module mcg_inv_leg (
  input  logic cmp1,
  input  logic cmp2,
  output logic hi,
  output logic lo
);
  always_comb begin
    hi = ~(cmp1 ^ cmp2);
    lo = ~hi;
  end
endmodule

// File: rtl/mcg_gate_decoder.sv
module mcg_gate_decoder
  import mcg_pkg::*;
#(
  parameter int NUM_LEGS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                period_start,
  input  logic [SEC_W-1:0]    sector_in,
  input  logic                rect_pwm,
  input  logic [NUM_LEGS-1:0] leg_cmp1,
  input  logic [NUM_LEGS-1:0] leg_cmp2,
  output logic [RECT_PH-1:0]  rect_hi,
  output logic [RECT_PH-1:0]  rect_lo,
  output logic [NUM_LEGS-1:0] inv_hi,
  output logic [NUM_LEGS-1:0] inv_lo
);
  sec_t                sector_q;
  rect_gates_t         rect_nxt;
  logic [NUM_LEGS-1:0] leg_hi_nxt;
  logic [NUM_LEGS-1:0] leg_lo_nxt;
  logic                enable;

  mcg_sector_hold u_hold (
    .clk          (clk),
    .rst          (rst),
    .period_start (period_start),
    .sector_in    (sector_in),
    .sector_q     (sector_q)
  );

  mcg_rect_route u_rect (
    .sector (sector_q),
    .pwm    (rect_pwm),
    .gates  (rect_nxt)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    mcg_inv_leg u_leg (
      .cmp1 (leg_cmp1[g]),
      .cmp2 (leg_cmp2[g]),
      .hi   (leg_hi_nxt[g]),
      .lo   (leg_lo_nxt[g])
    );
  end

  assign enable = sec_ok(sector_q);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      rect_hi <= '0;
      rect_lo <= '0;
      inv_hi  <= '0;
      inv_lo  <= '0;
    end else begin
      rect_hi <= rect_nxt.hi;
      rect_lo <= rect_nxt.lo;
      inv_hi  <= leg_hi_nxt;
      inv_lo  <= leg_lo_nxt;
    end
  end

  // R9: invalid held code shuts every gate next cycle
  a_r9_invalid_off: assert property (@(posedge clk) disable iff (rst)
    !sec_ok(sector_q) |=> (rect_hi == '0 && rect_lo == '0 && inv_hi == '0 && inv_lo == '0));

  // R7: one upper and one lower rectifier gate while routing
  a_r7_rect_pair: assert property (@(posedge clk) disable iff (rst)
    (rect_hi != '0 || rect_lo != '0) |-> ($countones(rect_hi) == 1 && $countones(rect_lo) == 1));

  // R7: no input phase shorted through both its switches
  a_r7_no_phase_short: assert property (@(posedge clk) disable iff (rst)
    (rect_hi & rect_lo) == '0);

  // R8: inverter legs strictly complementary when active
  a_r8_leg_complement: assert property (@(posedge clk) disable iff (rst)
    (inv_hi != '0 || inv_lo != '0) |-> ((inv_hi ^ inv_lo) == '1));

  // R11: valid held sector drives the registered XNOR of last cycle's pulses
  a_r11_inv_latency: assert property (@(posedge clk) disable iff (rst)
    sec_ok(sector_q) |=> (inv_hi == ~($past(leg_cmp1) ^ $past(leg_cmp2))));
endmodule

// File: tb/mcg_gate_decoder_tb.sv
module mcg_gate_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       period_start;
  logic [2:0] sector_in;
  logic       rect_pwm;
  logic [2:0] leg_cmp1, leg_cmp2;
  logic [2:0] rect_hi, rect_lo, inv_hi, inv_lo;

  int checks = 0;
  int errors = 0;
  logic [2:0] mdl_sec;
  bit done = 0;

  always #5 clk = ~clk;

  mcg_gate_decoder dut_i (
    .clk(clk), .rst(rst), .period_start(period_start), .sector_in(sector_in),
    .rect_pwm(rect_pwm), .leg_cmp1(leg_cmp1), .leg_cmp2(leg_cmp2),
    .rect_hi(rect_hi), .rect_lo(rect_lo), .inv_hi(inv_hi), .inv_lo(inv_lo)
  );

  // expected rectifier gates {lo, hi}, bit0 = a
  function automatic logic [5:0] exp_rect(input logic [2:0] s, input logic p);
    logic [2:0] h, l;
    h = 3'b000; l = 3'b000;
    case (s)
      3'd1: begin h[0] = 1; l[2] = p; l[1] = !p; end
      3'd2: begin l[2] = 1; h[0] = p; h[1] = !p; end
      3'd3: begin h[1] = 1; l[0] = p; l[2] = !p; end
      3'd4: begin l[0] = 1; h[1] = p; h[2] = !p; end
      3'd5: begin h[2] = 1; l[1] = p; l[0] = !p; end
      3'd6: begin l[1] = 1; h[0] = p; h[2] = !p; end
      default: ;
    endcase
    return {l, h};
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'd1: return "R1 R7";
      3'd2: return "R2 R7";
      3'd3: return "R3 R7";
      3'd4: return "R4 R7";
      3'd5: return "R5 R7";
      3'd6: return "R6 R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample at the following negedge
  task automatic step(input logic strobe, input logic [2:0] s, input logic p,
                      input logic [2:0] c1, input logic [2:0] c2, input string extra);
    logic [5:0] er, ei;
    logic       valid;
    period_start = strobe; sector_in = s; rect_pwm = p; leg_cmp1 = c1; leg_cmp2 = c2;
    valid = (mdl_sec != 3'd0) && (mdl_sec != 3'd7);
    er = exp_rect(mdl_sec, p);
    ei = valid ? {c1 ^ c2, ~(c1 ^ c2)} : 6'b0;
    if (strobe) mdl_sec = s;
    @(posedge clk);
    @(negedge clk);
    check({tag_of(er == 6'b0 ? 3'd0 : mdl_sec), extra}, {rect_lo, rect_hi}, er);
    check(valid ? {"R8", extra} : {"R9", extra}, {inv_lo, inv_hi}, ei);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    rst = 1; period_start = 0; sector_in = 3'd1; rect_pwm = 1; leg_cmp1 = 3'b101; leg_cmp2 = 3'b011;
    mdl_sec = 3'd0;
    @(negedge clk); @(negedge clk);
    // R11: reset state
    check("R11 reset rect", {rect_lo, rect_hi}, 6'b0);
    check("R11 reset inv", {inv_lo, inv_hi}, 6'b0);
    rst = 0;
    // R11: no strobe yet -> held sector invalid -> all off
    step(0, 3'd2, 1, 3'b111, 3'b000, " R11 pre-strobe");
    step(0, 3'd2, 0, 3'b000, 3'b000, " R11 pre-strobe");

    // every sector, pulse low and high (R1..R6, R7)
    for (int s = 1; s <= 6; s++) begin
      step(1, 3'(s), 0, 3'b000, 3'b000, " capture");
      step(0, 3'(s), 0, 3'b010, 3'b001, " pwm0");
      step(0, 3'(s), 1, 3'b100, 3'b110, " pwm1");
    end

    // R8: all four comparison combinations on every leg
    step(1, 3'd4, 1, 3'b000, 3'b000, " R8 00");
    step(0, 3'd4, 1, 3'b000, 3'b000, " R8 00");
    step(0, 3'd4, 0, 3'b111, 3'b000, " R8 10");
    step(0, 3'd4, 1, 3'b000, 3'b111, " R8 01");
    step(0, 3'd4, 0, 3'b111, 3'b111, " R8 11");

    // R10: code changes without strobe are ignored
    step(0, 3'd1, 1, 3'b001, 3'b000, " R10 ignored");
    step(0, 3'd0, 0, 3'b001, 3'b001, " R10 ignored");
    step(0, 3'd7, 1, 3'b011, 3'b010, " R10 ignored");

    // R9: invalid codes 0 and 7
    step(1, 3'd0, 1, 3'b101, 3'b000, " R9 code0");
    step(0, 3'd0, 0, 3'b000, 3'b000, " R9 code0");
    step(1, 3'd7, 1, 3'b110, 3'b011, " R9 code7");
    step(0, 3'd5, 0, 3'b000, 3'b111, " R9 code7");
    step(1, 3'd5, 1, 3'b010, 3'b010, " R9 exit");
    step(0, 3'd5, 1, 3'b010, 3'b010, " R5 after invalid");

    // constrained random: strobe about one cycle in eight, mostly valid codes
    for (int i = 0; i < 3000; i++) begin
      logic       st;
      logic [2:0] sc;
      st = ($urandom % 8) == 0;
      sc = (($urandom % 10) == 0) ? 3'(($urandom % 2) * 7) : 3'(1 + ($urandom % 6));
      step(st, sc, 1'($urandom), 3'($urandom), 3'($urandom), " R10 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule